// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital half of a successive approximation analog-to-digital converter. It drives the code of an external DAC and reads back one comparator bit that is high when the DAC level sits above the analog input. When a start request is seen while idle, it runs a binary search over the code. The search starts at the most significant bit and ends at the least significant one. Each trial sets one bit, holds the code steady for a programmable number of clock cycles so the DAC can settle, and then reads the comparator to decide whether the bit stays set.

After every decision, a second settle interval of the same length follows. This happens whether the bit was cleared or kept, so every conversion takes the same number of cycles for a given resolution. At the end, the code is copied to the result and a level done flag is raised. Both stay unchanged until the next start request is accepted. Start, done and the comparator are plain control pins. The result is held data with no handshake, and it may be read at any time while done is high.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is asserted, done is 0, result is 0 and dac_code is 0.
- R2: A start request seen at a clock edge while idle clears the search register and drives dac_code to the first trial code, with only the top bit set. In the same edge, done drops to 0.
- R3: Bits are tried from bit WIDTH-1 down to bit 0. Each trial code is held on dac_code for SETTLE cycles before the comparator is sampled at the edge that ends that interval.
- R4: When the sampled comparator is 1 (the DAC code is above the input), the trial bit is cleared. When it is 0, the bit stays set.
- R5: After each decision, dac_code is held for another SETTLE cycles before the next bit is tried. While a conversion runs, dac_code changes by at most one bit per cycle.
- R6: Every conversion takes exactly 2*SETTLE*WIDTH cycles. done is high after edge 2*SETTLE*WIDTH, counted from the edge that accepted the start request, and is low before it.
- R7: The result is the largest code whose DAC level does not exceed the input, so it rounds down. An input at or above full scale gives all ones.
- R8: done stays high, and result and dac_code stay unchanged, from the end of a conversion until the next accepted start request.
- R9: A start request seen while a conversion runs is ignored, including at the final edge of the conversion. That conversion's timing and result are unaffected.
- R10: During a conversion, result keeps the value of the previous conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| soc | input | 1 | Start request; accepted only while idle |
| cmp_hi | input | 1 | Comparator: 1 when the DAC level is above the analog input |
| dac_code | output | WIDTH | Code driven to the external DAC |
| result | output | WIDTH | Last completed conversion result |
| done | output | 1 | High from the end of a conversion until the next accepted start |

## Verification
The closing edge of a conversion can coincide with a new start request. The last settle interval ends and done rises on the same edge that samples soc. The bench provokes this by raising soc exactly for that edge. It then expects done to rise on time, the result to match, and done and the result to stay put for several idle cycles rather than a new search beginning. The comparator is modelled behind a delay line one cycle shorter than the settle interval, so a decision taken too early reads a stale level and gives a wrong result in the sweep.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRIAL = 2'd1,
    PH_HOLD  = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_settle_timer.sv
// Counts settle intervals of SETTLE cycles while running; expire marks the
// last cycle of each interval.
module sar_settle_timer #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expire
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (expire)   cnt <= '0;
    else if (run)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_approx_reg.sv
// Search register with a per-bit set/clear cell and a descending bit pointer.
module sar_approx_reg #(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 decide,
  input  logic                 reject,
  input  logic                 advance,
  output logic [WIDTH-1:0]     code,
  output logic [((WIDTH > 1) ? $clog2(WIDTH) : 1)-1:0] idx,
  output logic                 at_lsb
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IW-1:0] TOP = IW'(WIDTH - 1);

  logic [IW-1:0] idx_dn;
  logic          step;

  assign at_lsb = (idx == '0);
  assign idx_dn = idx - 1'b1;
  assign step   = advance && !at_lsb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (load)  idx <= TOP;
    else if (step)  idx <= idx_dn;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= 1'b0;
      else if (load)
        q <= (i == WIDTH - 1);
      else if (decide && reject && (idx == IW'(i)))
        q <= 1'b0;
      else if (step && (idx_dn == IW'(i)))
        q <= 1'b1;
    end
    assign code[i] = q;
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int WIDTH  = 8,
  parameter int SETTLE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soc,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  import sar_pkg::*;

  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  sar_phase_e    phase;
  logic          busy, start, expire, decide, advance, finish, at_lsb;
  logic [WIDTH-1:0] code;
  logic [IW-1:0] idx;

  assign busy    = (phase != PH_IDLE);
  assign start   = soc && !busy;
  assign decide  = expire && (phase == PH_TRIAL);
  assign advance = expire && (phase == PH_HOLD);
  assign finish  = advance && at_lsb;

  sar_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .run     (busy),
    .expire  (expire)
  );

  sar_approx_reg #(.WIDTH(WIDTH)) u_sreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .decide  (decide),
    .reject  (cmp_hi),
    .advance (advance),
    .code    (code),
    .idx     (idx),
    .at_lsb  (at_lsb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:  if (start)  phase <= PH_TRIAL;
        PH_TRIAL: if (expire) phase <= PH_HOLD;
        PH_HOLD:  if (expire) phase <= at_lsb ? PH_IDLE : PH_TRIAL;
        default:              phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else if (start) begin
      done   <= 1'b0;
    end else if (finish) begin
      done   <= 1'b1;
      result <= code;
    end
  end

  assign dac_code = code;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int WIDTH  = 8,
  parameter int SETTLE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] dac_code,
  input logic [WIDTH-1:0] result,
  input logic             done,
  input logic             busy,
  input logic [((WIDTH > 1) ? $clog2(WIDTH) : 1)-1:0] idx,
  input logic             sample_en
);
  localparam int CONV = 2 * SETTLE * WIDTH;
  localparam int RW   = $clog2(CONV + 2);

  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (busy)  run_len <= run_len + 1'b1;
    else            run_len <= '0;
  end

  // R6: conversion length is fixed
  a_r6_fixed_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (run_len == RW'(CONV)));

  // R5: single-bit steps on the DAC code during a conversion
  a_r5_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> ($countones(dac_code ^ $past(dac_code)) <= 1));

  // R9: bit pointer never jumps back up during a conversion
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> (idx <= $past(idx)));

  // R8: result only moves when a conversion completes
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $rose(done));

  // R8: done and an active conversion exclude each other
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  if (SETTLE > 1) begin : g_settle
    // R3: code is steady when the comparator is read
    a_r3_settled_sample: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |-> $stable(dac_code));
  end
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.WIDTH(WIDTH), .SETTLE(SETTLE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dac_code  (dac_code),
  .result    (result),
  .done      (done),
  .busy      (busy),
  .idx       (idx),
  .sample_en (decide)
);

// File: tb/sar_adc_ctrl_tb.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb;
  localparam int W    = 4;
  localparam int S    = 3;   // delay line below has S-1 stages
  localparam int CONV = 2 * S * W;
  localparam int MAXC = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         soc = 1'b0;
  logic         cmp_hi;
  logic [W-1:0] dac_code, result;
  logic         done;
  logic [W-1:0] d1, d2;
  int           vin2 = 0;      // analog input in half-LSB units
  int           n_tests = 0, n_fail = 0;
  int           prev_res = 0;
  bit           ended = 1'b0;

  always #2 clk = ~clk;

  // DAC that needs S-1 cycles before its level follows a new code
  always_ff @(posedge clk) begin
    d1 <= dac_code;
    d2 <= d1;
  end
  assign cmp_hi = (2 * int'(d2)) > vin2;

  sar_adc_ctrl #(.WIDTH(W), .SETTLE(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .soc(soc), .cmp_hi(cmp_hi),
    .dac_code(dac_code), .result(result), .done(done)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // soc_at: edge index (1..CONV) at which soc is also raised mid-conversion, 0 = none
  task automatic run_conv(int v2, int soc_at);
    int expv, trial, kept, j;
    expv = v2 / 2;
    if (expv > MAXC) expv = MAXC;
    vin2 = v2;
    @(negedge clk); soc = 1'b1;
    @(negedge clk); soc = 1'b0;               // after accepting edge E0
    chk(dac_code == W'(1 << (W - 1)), "R2 first trial", dac_code, 1 << (W - 1));
    chk(done == 1'b0, "R2 done drop", done, 0);
    for (int k = 1; k <= CONV; k++) begin
      soc = (k == soc_at);
      @(negedge clk);                         // after edge E_k
      if (k == 1) chk(result == W'(prev_res), "R10 result kept", result, prev_res);
      if (k < CONV) begin
        if (done) chk(1'b0, "R6 done early", done, 0);
        j = k / (2 * S);
        if (k % (2 * S) == 0) begin
          trial = ((expv >> (W - j)) << (W - j)) | (1 << (W - 1 - j));
          chk(dac_code == W'(trial), "R3 trial code", dac_code, trial);
        end else if (k % (2 * S) == S) begin
          kept = (expv >> (W - 1 - j)) << (W - 1 - j);
          chk(dac_code == W'(kept), "R4 decided code", dac_code, kept);
        end
      end else begin
        chk(done == 1'b1, "R6 done on time", done, 1);
        chk(result == W'(expv), "R7 result", result, expv);
        chk(dac_code == W'(expv), "R5 final code", dac_code, expv);
      end
    end
    soc = 1'b0;
    prev_res = expv;
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && result == '0 && dac_code == '0, "R1 reset state",
        int'({done, result, dac_code}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: sweep every half-LSB input level, including above full scale
    for (int v = 0; v <= 2 * (MAXC + 1) + 1; v++) run_conv(v, 0);

    // R9: soc mid-conversion is ignored
    run_conv(21, 5);
    run_conv(3, 1);

    // R9 / R8: soc on the final edge is ignored, then outputs persist
    run_conv(9, CONV);
    repeat (4) begin
      @(negedge clk);
      chk(done == 1'b1, "R8 done held", done, 1);
      chk(result == W'(4), "R8 result held", result, 4);
      chk(dac_code == W'(4), "R8 code held", dac_code, 4);
    end

    // back-to-back conversions at the extremes
    run_conv(0, 0);
    run_conv(31, 0);
    finish_run();
  end
endmodule